// File: doc/BRIEF.md
# Two-Level Block Carry-Lookahead Adder

This block adds two 16-bit operands and an incoming carry with no registers. The word is split into four 4-bit groups. Each group has its own lookahead unit, which forms every internal carry straight from bit-level generate/propagate terms. A second lookahead unit of the same design takes the four group generate/propagate pairs and forms the carry into groups 1 to 3 and the final carry-out. No carry ripples from bit to bit or from group to group.

A whole-word propagate and generate pair is also exported, so a wider adder can feed this one into a further lookahead level. The bit-level propagate is built as XOR by default. A parameter switches it to OR, and the carries come out identical either way.

Top module: `cla16_block_adder`

## Requirements
- R1: `{carry_out, sum_o}` equals the 17-bit arithmetic value of `opnd_a + opnd_b + carry_in` for every input combination.
- R2: With both operands zero and `carry_in` low, `sum_o`, `carry_out`, `word_prop` and `word_gen` are all 0.
- R3: With both operands 16'hFFFF and `carry_in` high, `sum_o` is 16'hFFFF, `carry_out` is 1, `word_gen` is 1 and `word_prop` is 0.
- R4: With `opnd_a` = 16'hFFFF, `opnd_b` = 0 and `carry_in` high, the carry travels through all 16 bits: `sum_o` is 0, `carry_out` is 1, `word_prop` is 1 and `word_gen` is 0.
- R5: A carry leaving group k (bits 4k..4k+3, k = 0..3) arrives at the next group. With `opnd_a` set to ones in bits 0..4k+3, `opnd_b` = 1 and `carry_in` low, `sum_o` is 1 shifted left by 4(k+1), and `carry_out` is 1 only for k = 3.
- R6: With the default XOR propagate form (`PROP_XOR` = 1), `word_prop` is 1 exactly when every bit of `opnd_a ^ opnd_b` is 1.
- R7: `word_gen` equals the carry-out of `opnd_a + opnd_b` with no carry-in.
- R8: `carry_out` equals `word_gen | (word_prop & carry_in)`.
- R9: An instance built with the OR propagate form (`PROP_XOR` = 0) gives the same `sum_o` and `carry_out` as the XOR form for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| word_prop | output | 1 | Whole-word propagate, for a further lookahead level |
| word_gen | output | 1 | Whole-word generate, for a further lookahead level |

## Verification
The all-zero and all-ones patterns fix the two ends of the result range. The all-ones case also separates generate from propagate on the word outputs. An operand of all ones plus a carry-in sends one carry through every bit and both lookahead levels. A carry started inside one group at a time shows whether each group-to-group link in the second-level unit is wired to the right group. Random vectors cover mixed generate/propagate patterns against a behavioural 17-bit sum, and an OR-propagate instance that sees the same stimulus has to give the same sum and carry-out.

// File: rtl/cla_pkg.sv
// Package: shared sizing for the block carry-lookahead adder.
// Assumes two lookahead levels of equal fan-in.
package cla_pkg;
    localparam int unsigned CLA_GROUP_W  = 4;
    localparam int unsigned CLA_N_GROUPS = 4;
    localparam int unsigned CLA_WIDTH    = CLA_GROUP_W * CLA_N_GROUPS;
endpackage

// File: rtl/cla_bit_fa.sv
// Module: cla_bit_fa
// A one-bit full adder with no carry output. It emits the sum, the bit generate and
// the bit propagate. The carry-in always comes from lookahead logic.
// PROP_XOR selects the propagate form: 1 gives XOR, 0 gives OR.
module cla_bit_fa #(
    parameter bit PROP_XOR = 1'b1
) (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_bit,
    output logic s_bit,
    output logic g_bit,
    output logic p_bit
);
    // Sum and generate do not depend on the propagate form.
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_bit;
        g_bit = a_bit & b_bit;
    end

    generate
        if (PROP_XOR) begin : g_prop_xor
            // Propagate as XOR; it holds only when exactly one operand bit is set.
            always_comb p_bit = a_bit ^ b_bit;
        end else begin : g_prop_or
            // Propagate as OR; it also holds when both operand bits are set.
            always_comb p_bit = a_bit | b_bit;
        end
    endgenerate
endmodule

// File: rtl/cla_lookahead_unit.sv
// Module: cla_lookahead_unit
// Flat lookahead carry unit for W positions. Each carry c[i+1] is a single
// sum of products over g[0..i], p[0..i] and c_in; no carry feeds another carry.
// The unit also returns the group propagate (AND of all p) and the group
// generate (the top carry with c_in taken as 0). The same unit serves both levels.
module cla_lookahead_unit #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    input  logic         c_in,
    output logic [W:1]   c_out,
    output logic         grp_p,
    output logic         grp_g
);
    // Expanded sum of products for every carry position.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            logic acc;
            logic all_p;
            all_p = 1'b1;
            for (int k = 0; k <= i; k++) all_p = all_p & p_in[k];
            acc = all_p & c_in;
            for (int j = 0; j <= i; j++) begin
                logic term;
                term = g_in[j];
                for (int k = j + 1; k <= i; k++) term = term & p_in[k];
                acc = acc | term;
            end
            c_out[i+1] = acc;
        end
    end

    // Group propagate and generate, for the next lookahead level.
    always_comb begin
        logic gacc;
        grp_p = &p_in;
        gacc  = 1'b0;
        for (int j = 0; j < W; j++) begin
            logic term;
            term = g_in[j];
            for (int k = j + 1; k < W; k++) term = term & p_in[k];
            gacc = gacc | term;
        end
        grp_g = gacc;
    end
endmodule

// File: rtl/cla_group_adder.sv
// Module: cla_group_adder
// A W-bit lookahead adder group made of W one-bit adders and one lookahead unit.
// It exports the group propagate and generate for the second level, and its own
// top carry (grp_cout) so a checker can compare it with the second level.
module cla_group_adder #(
    parameter int unsigned W        = 4,
    parameter bit          PROP_XOR = 1'b1
) (
    input  logic [W-1:0] a_grp,
    input  logic [W-1:0] b_grp,
    input  logic         c_grp,
    output logic [W-1:0] s_grp,
    output logic         p_grp,
    output logic         g_grp,
    output logic         grp_cout
);
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W:1]   la_c;
    logic [W-1:0] bit_c;

    // Bit 0 takes the group carry-in; the other bits take lookahead carries.
    always_comb begin
        bit_c[0] = c_grp;
        for (int i = 1; i < W; i++) bit_c[i] = la_c[i];
        grp_cout = la_c[W];
    end

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            cla_bit_fa #(.PROP_XOR(PROP_XOR)) u_fa (
                .a_bit (a_grp[gi]),
                .b_bit (b_grp[gi]),
                .c_bit (bit_c[gi]),
                .s_bit (s_grp[gi]),
                .g_bit (bit_g[gi]),
                .p_bit (bit_p[gi])
            );
        end
    endgenerate

    cla_lookahead_unit #(.W(W)) u_la (
        .g_in  (bit_g),
        .p_in  (bit_p),
        .c_in  (c_grp),
        .c_out (la_c),
        .grp_p (p_grp),
        .grp_g (g_grp)
    );
endmodule

// File: rtl/cla16_block_adder.sv
// Module: cla16_block_adder
// A 16-bit two-level block carry-lookahead adder built from N_GROUPS lookahead
// groups. A second-level lookahead unit, the same module as inside each group,
// forms every group carry-in and the final carry. The block is purely
// combinational, so it has no clock and no reset.
module cla16_block_adder #(
    parameter int unsigned GROUP_W  = cla_pkg::CLA_GROUP_W,
    parameter int unsigned N_GROUPS = cla_pkg::CLA_N_GROUPS,
    parameter bit          PROP_XOR = 1'b1
) (
    input  logic [GROUP_W*N_GROUPS-1:0] opnd_a,
    input  logic [GROUP_W*N_GROUPS-1:0] opnd_b,
    input  logic                        carry_in,
    output logic [GROUP_W*N_GROUPS-1:0] sum_o,
    output logic                        carry_out,
    output logic                        word_prop,
    output logic                        word_gen
);
    localparam int unsigned WIDTH = GROUP_W * N_GROUPS;

    logic [N_GROUPS-1:0] grp_p_v;
    logic [N_GROUPS-1:0] grp_g_v;
    logic [N_GROUPS-1:0] grp_local_c;
    logic [N_GROUPS:1]   lvl2_c;
    logic [N_GROUPS:0]   grp_cin;

    // Group 0 takes the external carry; the other groups take second-level carries.
    always_comb begin
        grp_cin[0] = carry_in;
        for (int i = 1; i <= N_GROUPS; i++) grp_cin[i] = lvl2_c[i];
        carry_out = lvl2_c[N_GROUPS];
    end

    genvar gk;
    generate
        for (gk = 0; gk < N_GROUPS; gk++) begin : g_grp
            cla_group_adder #(.W(GROUP_W), .PROP_XOR(PROP_XOR)) u_grp (
                .a_grp    (opnd_a[gk*GROUP_W +: GROUP_W]),
                .b_grp    (opnd_b[gk*GROUP_W +: GROUP_W]),
                .c_grp    (grp_cin[gk]),
                .s_grp    (sum_o[gk*GROUP_W +: GROUP_W]),
                .p_grp    (grp_p_v[gk]),
                .g_grp    (grp_g_v[gk]),
                .grp_cout (grp_local_c[gk])
            );
        end
    endgenerate

    cla_lookahead_unit #(.W(N_GROUPS)) u_lvl2 (
        .g_in  (grp_g_v),
        .p_in  (grp_p_v),
        .c_in  (carry_in),
        .c_out (lvl2_c),
        .grp_p (word_prop),
        .grp_g (word_gen)
    );
endmodule

// File: rtl/cla16_block_adder_chk.sv
// Module: cla16_block_adder_chk
// Assertion checker bound into cla16_block_adder. The block has no clock, so the
// checks are immediate assertions on the settled combinational values.
module cla16_block_adder_chk #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned N_GROUPS = 4,
    parameter bit          PROP_XOR = 1'b1
) (
    input logic [WIDTH-1:0]  opnd_a,
    input logic [WIDTH-1:0]  opnd_b,
    input logic              carry_in,
    input logic [WIDTH-1:0]  sum_o,
    input logic              carry_out,
    input logic              word_prop,
    input logic              word_gen,
    input logic [N_GROUPS:0] grp_cin,
    input logic [N_GROUPS-1:0] grp_local_c
);
    // Arithmetic result, word generate and carry composition.
    always_comb begin
        logic [WIDTH:0] ref_full;
        logic [WIDTH:0] ref_nocin;
        ref_full  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        ref_nocin = {1'b0, opnd_a} + {1'b0, opnd_b};
        AST_SUM_MATCH: assert ({carry_out, sum_o} == ref_full);                    // R1
        AST_GEN_IS_COUT: assert (word_gen == ref_nocin[WIDTH]);                    // R7
        AST_COUT_COMPOSE: assert (carry_out == (word_gen | (word_prop & carry_in))); // R8
    end

    // Each group's own top carry agrees with the second-level carry after it.
    always_comb begin
        for (int i = 0; i < N_GROUPS; i++) begin
            AST_GROUP_CARRY_AGREE: assert (grp_local_c[i] == grp_cin[i+1]);       // R5
        end
    end

    generate
        if (PROP_XOR) begin : g_xor_chk
            // With XOR propagate, word propagate means every bit pair differs.
            always_comb begin
                AST_PROP_ALL_DIFFER: assert (word_prop == (&(opnd_a ^ opnd_b)));  // R6
            end
        end
    endgenerate
endmodule

bind cla16_block_adder cla16_block_adder_chk #(
    .WIDTH    (WIDTH),
    .N_GROUPS (N_GROUPS),
    .PROP_XOR (PROP_XOR)
) u_chk (
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .carry_in    (carry_in),
    .sum_o       (sum_o),
    .carry_out   (carry_out),
    .word_prop   (word_prop),
    .word_gen    (word_gen),
    .grp_cin     (grp_cin),
    .grp_local_c (grp_local_c)
);

// File: tb/cla16_block_adder_tb.sv
// Bench for cla16_block_adder. One vector is applied per clock after the rising
// edge and compared at the falling edge against a behavioural integer model.
module cla16_block_adder_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum_x, sum_r;
    logic         cout_x, cout_r, wp_x, wg_x, wp_r, wg_r;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    cla16_block_adder u_dut (
        .opnd_a(a), .opnd_b(b), .carry_in(cin),
        .sum_o(sum_x), .carry_out(cout_x), .word_prop(wp_x), .word_gen(wg_x)
    );

    cla16_block_adder #(.PROP_XOR(1'b0)) u_dut_or (
        .opnd_a(a), .opnd_b(b), .carry_in(cin),
        .sum_o(sum_r), .carry_out(cout_r), .word_prop(wp_r), .word_gen(wg_r)
    );

    // Count one comparison; print a FAIL line on mismatch.
    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one vector and compare every output with the behavioural model.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc, input string req);
        int full;
        int nocin;
        int pxor;
        @(posedge clk);
        #1;
        a = va; b = vb; cin = vc;
        full  = int'(va) + int'(vb) + int'(vc);
        nocin = int'(va) + int'(vb);
        pxor  = ((va ^ vb) == 16'hFFFF) ? 1 : 0;
        @(negedge clk);
        check(req, "sum", longint'(sum_x), longint'(full % 65536));
        check(req, "cout", longint'(cout_x), longint'(full / 65536));
        check("R6", "word_prop", longint'(wp_x), longint'(pxor));
        check("R7", "word_gen", longint'(wg_x), longint'(nocin / 65536));
        check("R8", "cout compose", longint'(cout_x), longint'(wg_x | (wp_x & vc)));
        check("R9", "or-form sum", longint'(sum_r), longint'(full % 65536));
        check("R9", "or-form cout", longint'(cout_r), longint'(full / 65536));
    endtask

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected <= 100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R2: all zeros
        apply(16'h0000, 16'h0000, 1'b0, "R2");
        check("R2", "word_prop", longint'(wp_x), 0);
        check("R2", "word_gen", longint'(wg_x), 0);

        // R3: all ones plus carry-in
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R3");
        check("R3", "sum", longint'(sum_x), 64'hFFFF);
        check("R3", "cout", longint'(cout_x), 1);
        check("R3", "word_gen", longint'(wg_x), 1);
        check("R3", "word_prop", longint'(wp_x), 0);

        // R4: carry through all 16 bits
        apply(16'hFFFF, 16'h0000, 1'b1, "R4");
        check("R4", "sum", longint'(sum_x), 0);
        check("R4", "cout", longint'(cout_x), 1);
        check("R4", "word_prop", longint'(wp_x), 1);
        check("R4", "word_gen", longint'(wg_x), 0);
        apply(16'h0000, 16'hFFFF, 1'b1, "R4");
        check("R4", "sum swapped", longint'(sum_x), 0);

        // R5: carry crossing each group boundary
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] m;
            m = 16'((32'd1 << (4 * (k + 1))) - 1);
            apply(m, 16'h0001, 1'b0, "R5");
            check("R5", "boundary sum", longint'(sum_x), longint'((32'd1 << (4 * (k + 1))) & 32'hFFFF));
            check("R5", "boundary cout", longint'(cout_x), (k == 3) ? 1 : 0);
            apply(m, 16'h0000, 1'b1, "R5");
        end

        // R1: random vectors
        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
        end
        // R1: complementary operands, where every bit propagates
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] r;
            r = 16'($urandom);
            apply(r, ~r, 1'($urandom), "R1");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule